// File: doc/BRIEF.md
# Serial Register Front-End for a Data-Acquisition Converter

This block is the two-wire bus slave that sits in front of a small converter core. It oversamples SCL and SDA with a fast system clock and finds bus conditions on the synchronized copies. It answers a 7-bit device address built from a fixed prefix and three strap pins. Once selected, it either takes bytes into a control register and a DAC data register, or sends conversion results out over the bus.

Reads are pipelined. Every acknowledge clock in a read transfer fires a one-cycle conversion-start strobe toward the converter core. The byte shifted out after that acknowledge is the newest result the core has returned, so each transmitted byte belongs to the conversion launched one acknowledge earlier. The core hands each result back on a data bus with a one-cycle valid pulse. Until the first result arrives, the held value reads 0x80.

SDA is open-drain. The block only asserts an output enable that pulls the line low, and SCL is never driven.

Top module: `acq_bus_regs`

## Requirements
- R1: After reset the control and DAC outputs are 0x00, the SDA pull-down enable is low and the conversion strobe is low.
- R2: An address byte whose upper four bits are 1001 and whose next three bits equal strap_i (bit 2 first) is acknowledged by pulling SDA low for the ninth clock. The byte's last bit selects read (1) or write (0).
- R3: An address byte that does not match gets no acknowledge. The block then leaves SDA released, changes no register and fires no strobe until the next START or STOP.
- R4: In a write transfer, the first byte after the address goes to the control output. Bits 7 and 3 of the control output always read 0, whatever was written.
- R5: Each later byte of the same write transfer replaces the DAC output, which then holds until the next accepted data byte. Every accepted byte is acknowledged.
- R6: A STOP or a repeated START ends a write transfer. The first byte written after a new matching address goes to the control register again.
- R7: Read bytes are sent MSB first. The first byte read after reset is 0x80.
- R8: In a read transfer, each acknowledge clock fires the conversion strobe for exactly one system clock, after that clock's falling edge. This covers the address acknowledge and both acknowledged and unacknowledged data bytes. No strobe fires during write transfers.
- R9: Each read byte equals the most recent result delivered on res_data_i/res_valid_i before the strobe that precedes that byte.
- R10: After the master leaves a read byte unacknowledged, the block keeps SDA released on every further clock until the next START or STOP.
- R11: START (SDA falling) and STOP (SDA rising) are recognised only while SCL is high. SDA changes while SCL is low are plain data.
- R12: The SDA pull-down enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Low address bits from strap pins |
| ctrl_o | output | 8 | Control register (bits 7 and 3 forced 0) |
| dac_o | output | 8 | DAC data register |
| res_data_i | input | 8 | Conversion result from the core |
| res_valid_i | input | 1 | One-cycle pulse: res_data_i holds a new result |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |

## Verification
A bit-counter or state slip inside the block shows up at the ports within one byte time. The acknowledge lands on the wrong clock, the bench's acknowledge sample reads high, and the next byte goes to the wrong register. The bench watches ctrl_o and dac_o on every clock against a behavioural model once the design has had a few cycles to settle after each SCL edge, so a misrouted byte is caught within about ten cycles of its ninth clock. A wrong read pipeline shows as a byte that matches the converter model's earlier or later result instead of the latest one, and as a strobe count that differs from the number of read acknowledge clocks.

// File: rtl/acq_bus_pkg.sv
package acq_bus_pkg;

   // Transfer phases of the bus slave.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK,
      ST_IGNORE
   } xfer_st_t;

endpackage

// File: rtl/acq_line_sync.sv
// Two-line synchronizer with edge and bus-condition detection.
module acq_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   if (STAGES < 2) begin : g_bad_stages
      $error("acq_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   // Idle bus is high, so the chain resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // Conditions only count while SCL is high on both samples.
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/acq_xfer_ctl.sv
// Transfer sequencer: address match, byte shifting, acknowledge, strobe.
module acq_xfer_ctl
   import acq_bus_pkg::*;
#(
   parameter int                 DATA_W     = 8,
   parameter int                 STRAP_W    = 3,
   parameter int                 FIXED_W    = 4,
   parameter logic [FIXED_W-1:0] ADDR_FIXED = 4'b1001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_s,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic [STRAP_W-1:0] strap,
   input  logic [DATA_W-1:0]  tx_data,
   output logic               sda_oe,
   output logic               conv_start,
   output logic               wr_ctrl_en,
   output logic               wr_dac_en,
   output logic [DATA_W-1:0]  wr_data
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (FIXED_W + STRAP_W + 1 != DATA_W) begin : g_bad_addr
      $error("acq_xfer_ctl: prefix + strap + direction bit must fill one byte");
   end

   xfer_st_t           st;
   logic [CNT_W-1:0]   bitcnt;
   logic [DATA_W-1:0]  shreg;
   logic               is_read;
   logic               first_wr;
   logic               mack;
   logic               addr_hit;

   assign addr_hit = (shreg[DATA_W-1:1] == {ADDR_FIXED, strap});
   assign wr_data  = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bitcnt     <= '0;
         shreg      <= '0;
         is_read    <= 1'b0;
         first_wr   <= 1'b0;
         mack       <= 1'b0;
         sda_oe     <= 1'b0;
         conv_start <= 1'b0;
         wr_ctrl_en <= 1'b0;
         wr_dac_en  <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         wr_ctrl_en <= 1'b0;
         wr_dac_en  <= 1'b0;
         if (bus_start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (bus_stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise && bitcnt != BITS) begin
                     shreg  <= {shreg[DATA_W-2:0], sda_s};
                     bitcnt <= bitcnt + CNT_W'(1);
                  end else if (scl_fall && bitcnt == BITS) begin
                     if (addr_hit) begin
                        sda_oe  <= 1'b1;
                        is_read <= shreg[0];
                        st      <= ST_ADDR_ACK;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_read) begin
                        conv_start <= 1'b1;
                        shreg      <= tx_data;
                        sda_oe     <= ~tx_data[DATA_W-1];
                        st         <= ST_RD_BYTE;
                     end else begin
                        sda_oe   <= 1'b0;
                        first_wr <= 1'b1;
                        st       <= ST_WR_BYTE;
                     end
                  end
               end
               ST_WR_BYTE: begin
                  if (scl_rise && bitcnt != BITS) begin
                     shreg  <= {shreg[DATA_W-2:0], sda_s};
                     bitcnt <= bitcnt + CNT_W'(1);
                  end else if (scl_fall && bitcnt == BITS) begin
                     sda_oe     <= 1'b1;
                     wr_ctrl_en <= first_wr;
                     wr_dac_en  <= ~first_wr;
                     first_wr   <= 1'b0;
                     st         <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     st     <= ST_WR_BYTE;
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST) begin
                        sda_oe <= 1'b0;
                        st     <= ST_RD_ACK;
                     end else begin
                        bitcnt <= bitcnt + CNT_W'(1);
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        sda_oe <= ~shreg[DATA_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     conv_start <= 1'b1;
                     bitcnt     <= '0;
                     if (mack) begin
                        shreg  <= tx_data;
                        sda_oe <= ~tx_data[DATA_W-1];
                        st     <= ST_RD_BYTE;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               ST_IGNORE: begin
                  sda_oe <= 1'b0;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R12
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R8
   AST_STROBE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !scl_s); // R8
   AST_STROBE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> is_read); // R8
   AST_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_IGNORE) |-> !sda_oe); // R10

endmodule

// File: rtl/acq_reg_bank.sv
// Control, DAC and held-result registers.
module acq_reg_bank #(
   parameter int                DATA_W      = 8,
   parameter logic [DATA_W-1:0] RSVD_MASK   = 8'h88,
   parameter logic [DATA_W-1:0] RESULT_INIT = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl_en,
   input  logic              wr_dac_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] res_data,
   input  logic              res_valid,
   output logic [DATA_W-1:0] ctrl,
   output logic [DATA_W-1:0] dac,
   output logic [DATA_W-1:0] held
);

   // Reserved control bits have no storage; live bits get a flop each.
   for (genvar i = 0; i < DATA_W; i++) begin : g_ctrl_bit
      if (RSVD_MASK[i]) begin : g_rsvd
         assign ctrl[i] = 1'b0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ctrl[i] <= 1'b0;
            else if (wr_ctrl_en) ctrl[i] <= wr_data[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dac <= '0;
      else if (wr_dac_en) dac <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held <= RESULT_INIT;
      else if (res_valid) held <= res_data;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctrl_en && wr_dac_en)); // R4
   AST_HELD_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held) |-> $past(res_valid)); // R9

endmodule

// File: rtl/acq_bus_regs.sv
// Top: serial register front-end for the converter core.
module acq_bus_regs #(
   parameter int                 DATA_W      = 8,
   parameter int                 STRAP_W     = 3,
   parameter int                 FIXED_W     = 4,
   parameter logic [FIXED_W-1:0] ADDR_FIXED  = 4'b1001,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0]  RSVD_MASK   = 8'h88,
   parameter logic [DATA_W-1:0]  RESULT_INIT = 8'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic [STRAP_W-1:0] strap_i,
   output logic [DATA_W-1:0]  ctrl_o,
   output logic [DATA_W-1:0]  dac_o,
   input  logic [DATA_W-1:0]  res_data_i,
   input  logic               res_valid_i,
   output logic               conv_start_o
);

   logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic              wr_ctrl_en, wr_dac_en;
   logic [DATA_W-1:0] wr_data, held;

   acq_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   acq_xfer_ctl #(
      .DATA_W     (DATA_W),
      .STRAP_W    (STRAP_W),
      .FIXED_W    (FIXED_W),
      .ADDR_FIXED (ADDR_FIXED)
   ) i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .bus_start  (bus_start),
      .bus_stop   (bus_stop),
      .strap      (strap_i),
      .tx_data    (held),
      .sda_oe     (sda_oe_o),
      .conv_start (conv_start_o),
      .wr_ctrl_en (wr_ctrl_en),
      .wr_dac_en  (wr_dac_en),
      .wr_data    (wr_data)
   );

   acq_reg_bank #(
      .DATA_W      (DATA_W),
      .RSVD_MASK   (RSVD_MASK),
      .RESULT_INIT (RESULT_INIT)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl_en (wr_ctrl_en),
      .wr_dac_en  (wr_dac_en),
      .wr_data    (wr_data),
      .res_data   (res_data_i),
      .res_valid  (res_valid_i),
      .ctrl       (ctrl_o),
      .dac        (dac_o),
      .held       (held)
   );

   AST_CTRL_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> sda_oe_o); // R4
   AST_DAC_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_o) |-> sda_oe_o); // R5

endmodule

// File: tb/test_acq_bus_regs.sv
module test_acq_bus_regs;

   localparam int Q = 10;  // system clocks per quarter SCL period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic [2:0] strap = 3'b101;
   logic [7:0] ctrl_o, dac_o;
   logic [7:0] res_data = 8'h00;
   logic       res_valid = 1'b0;
   logic       conv_start;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   acq_bus_regs i_acq_bus_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe_o     (sda_oe),
      .strap_i      (strap),
      .ctrl_o       (ctrl_o),
      .dac_o        (dac_o),
      .res_data_i   (res_data),
      .res_valid_i  (res_valid),
      .conv_start_o (conv_start)
   );

   int tests = 0, fails = 0;
   int mon_tests = 0, mon_fails = 0;
   logic [7:0] exp_ctrl = 8'h00, exp_dac = 8'h00;
   logic       mon_on = 1'b0;

   // Converter core model: result returns 20 clocks after each strobe.
   int         n_strobe = 0;
   int         cdown = 0;
   logic [7:0] last_done = 8'h80;
   always @(negedge clk) begin
      res_valid = 1'b0;
      if (conv_start) begin
         cdown = 20;
         n_strobe++;
      end else if (cdown > 0) begin
         cdown--;
         if (cdown == 0) begin
            res_data  = 8'h31 + 8'(n_strobe - 1) * 8'h17;
            res_valid = 1'b1;
            last_done = res_data;
         end
      end
   end

   // Per-clock register model compare and SDA-drive timing rule.
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   int   quiet = 0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (scl_m != scl_prev) quiet = 8;
         else if (quiet > 0) quiet--;
         if (quiet == 0) begin
            mon_tests++;
            if (ctrl_o !== exp_ctrl) begin
               mon_fails++;
               $display("FAIL R4 ctrl_o actual %h expected %h", ctrl_o, exp_ctrl);
            end
            mon_tests++;
            if (dac_o !== exp_dac) begin
               mon_fails++;
               $display("FAIL R5 dac_o actual %h expected %h", dac_o, exp_dac);
            end
         end
         if (scl_m && scl_prev && sda_oe !== oe_prev) begin
            mon_fails++;
            $display("FAIL R12 sda_oe changed with SCL high actual %b expected %b", sda_oe, oe_prev);
         end
      end
      scl_prev = scl_m;
      oe_prev  = sda_oe;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_q(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wait_q();
      scl_m = 1'b1; wait_q(2);
      scl_m = 1'b0; wait_q();
   endtask

   task automatic recv_bit(output logic b, output logic low_seen);
      sda_m = 1'b1; wait_q();
      low_seen = ~sda_line;
      scl_m = 1'b1; wait_q();
      b = sda_line;
      wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   // kind: 0 no model update, 1 control register, 2 DAC register
   task automatic write_byte(input logic [7:0] d, input int kind, output logic acked);
      logic b, lo;
      for (int i = 7; i >= 0; i--) begin
         sda_m = d[i]; wait_q();
         scl_m = 1'b1; wait_q(2);
         if (i == 0 && kind == 1) exp_ctrl = d & 8'h77;
         if (i == 0 && kind == 2) exp_dac = d;
         scl_m = 1'b0; wait_q();
      end
      recv_bit(b, lo);
      acked = ~b;
   endtask

   task automatic read_byte(output logic [7:0] d, input logic mack);
      logic lo;
      for (int i = 7; i >= 0; i--) recv_bit(d[i], lo);
      send_bit(~mack);
   endtask

   logic       ack;
   logic [7:0] rd, exp_rd;
   int         strobes0;
   logic       bit_v, lo_v;

   initial begin
      repeat (5) @(negedge clk);
      check("R1 ctrl_o reset", 32'(ctrl_o), 32'h00);
      check("R1 dac_o reset", 32'(dac_o), 32'h00);
      check("R1 sda_oe reset", 32'(sda_oe), 32'h0);
      check("R1 conv_start reset", 32'(conv_start), 32'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      mon_on = 1'b1;

      // Write: address 1001_101, control then two DAC bytes.
      bus_start();
      write_byte({7'h4D, 1'b0}, 0, ack);
      check("R2 write address acknowledged", 32'(ack), 32'h1);
      write_byte(8'hFF, 1, ack);
      check("R4 control byte acknowledged", 32'(ack), 32'h1);
      check("R4 reserved bits read zero", 32'(ctrl_o), 32'h77);
      write_byte(8'hA5, 2, ack);
      check("R11 toggling data byte reaches DAC", 32'(dac_o), 32'hA5);
      write_byte(8'h3C, 2, ack);
      check("R5 second DAC byte acknowledged", 32'(ack), 32'h1);
      check("R5 DAC overwritten", 32'(dac_o), 32'h3C);
      bus_stop();
      check("R8 no strobe during write", 32'(n_strobe), 32'd0);

      // Mismatching address: no acknowledge, nothing changes.
      bus_start();
      write_byte({7'h4C, 1'b0}, 0, ack);
      check("R3 wrong address not acknowledged", 32'(ack), 32'h0);
      write_byte(8'h00, 0, ack);
      check("R3 later byte not acknowledged", 32'(ack), 32'h0);
      write_byte(8'h11, 0, ack);
      check("R3 control kept", 32'(ctrl_o), 32'h77);
      check("R3 DAC kept", 32'(dac_o), 32'h3C);
      bus_stop();

      // Repeated START restarts at the control register.
      bus_start();
      write_byte({7'h4D, 1'b0}, 0, ack);
      write_byte(8'h45, 1, ack);
      check("R4 control rewritten", 32'(ctrl_o), 32'h45);
      bus_start();
      write_byte({7'h4D, 1'b0}, 0, ack);
      check("R6 address after repeated START acknowledged", 32'(ack), 32'h1);
      write_byte(8'h12, 1, ack);
      check("R6 first byte after repeated START to control", 32'(ctrl_o), 32'h12);
      check("R6 DAC untouched by control write", 32'(dac_o), 32'h3C);
      write_byte(8'h99, 2, ack);
      check("R5 DAC after repeated START", 32'(dac_o), 32'h99);
      bus_stop();

      // Read: pipelined results.
      bus_start();
      write_byte({7'h4D, 1'b1}, 0, ack);
      check("R2 read address acknowledged", 32'(ack), 32'h1);
      check("R8 strobe on address acknowledge", 32'(n_strobe), 32'd1);
      exp_rd = last_done;
      read_byte(rd, 1'b1);
      check("R7 first read after reset", 32'(rd), 32'h80);
      check("R9 byte 0 matches held result", 32'(rd), 32'(exp_rd));
      exp_rd = last_done;
      check("R8 strobe on data acknowledge", 32'(n_strobe), 32'd2);
      read_byte(rd, 1'b1);
      check("R9 byte 1 is first conversion", 32'(rd), 32'(exp_rd));
      check("R9 first conversion value", 32'(rd), 32'h31);
      exp_rd = last_done;
      read_byte(rd, 1'b0);
      check("R9 byte 2 is second conversion", 32'(rd), 32'h48);
      check("R8 strobe on unacknowledged byte", 32'(n_strobe), 32'd4);
      recv_bit(bit_v, lo_v);
      check("R10 SDA released after NACK", 32'({bit_v, lo_v}), 32'h2);
      recv_bit(bit_v, lo_v);
      check("R10 SDA still released", 32'({bit_v, lo_v}), 32'h2);
      bus_stop();
      check("R8 no strobe after NACK clocks", 32'(n_strobe), 32'd4);

      // Second read: first byte from the conversion launched at the NACK.
      bus_start();
      write_byte({7'h4D, 1'b1}, 0, ack);
      exp_rd = last_done;
      read_byte(rd, 1'b0);
      check("R9 read after NACK-launched conversion", 32'(rd), 32'h76);
      check("R9 matches converter model", 32'(rd), 32'(exp_rd));
      check("R8 strobes in second read", 32'(n_strobe), 32'd6);
      bus_stop();

      // Wrong-address read: no strobe, no drive.
      strobes0 = n_strobe;
      bus_start();
      write_byte({7'h4B, 1'b1}, 0, ack);
      check("R3 wrong read address not acknowledged", 32'(ack), 32'h0);
      read_byte(rd, 1'b1);
      check("R3 no data driven", 32'(rd), 32'hFF);
      check("R3 no strobe", 32'(n_strobe), 32'(strobes0));
      bus_stop();

      repeat (20) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
      $finish;
   end

endmodule